// File: doc/BRIEF.md
# Two-wire register and memory slave with write lock

This block is the serial-bus front end of a supply supervisor. It listens on a two-wire bus (SCL/SDA, open drain), answers two device-type identifiers, and routes each access to one of four places. The first place is a register region that holds command/status bytes, two extra configuration bytes, the lock register and the converter readout. The other three are two 256-byte halves of a general-purpose memory and a one-page configuration bank. Writes to memory and configuration are gathered into a page buffer and committed when the master sends stop. Reads use a dummy write to set the word pointer, then a repeated start. Writes to the register region take effect at once.

A volatile lock register gates every write to memory and to configuration. While a transaction addressed to this block is in progress, the block raises a halt request to the voltage monitor. A read of a converter channel is a handshake with an external converter. The slave refuses its address until the conversion is finished, so the master polls for the result.

Top module: `i2c_wp_slave`

## Requirements
- R1: The slave acknowledges address byte {id[3:0], a2, a1, a0, rw} only when it hits. A hit is id = 1001 with {a1,a0} = cfg_cmd_a10 (register region), or id = 1010 (1011 when cfg_alt_id = 1) with {a1,a0} = 00 (memory low half), 01 (memory high half) or 11 (configuration bank). Every other address byte, including memory id with {a1,a0} = 10, is left unacknowledged.
- R2: The a2 bit must equal a2_pin when cfg_a2_pin = 1, and must be 0 when cfg_a2_pin = 0.
- R3: A write is address, word pointer, then data. A read is a dummy write of the pointer, then a repeated start with rw = 1. Sequential read bytes come from consecutive addresses, and a master NACK ends the read.
- R4: Memory and configuration writes hold up to 16 bytes. The pointer's low 4 bits wrap inside the page, so byte 17 would land on the page's first position again.
- R5: Memory and configuration writes become visible only after stop. A read by repeated start before stop returns the old contents.
- R6: After reset the lock register (pointer 0x87, register region) reads 0x00, which locks everything. A write to a locked region is acknowledged and discarded.
- R7: Lock bits [7:4] = 0101 unlock both memory halves, and bits [3:0] = 0101 unlock the configuration bank. Writing any other code locks that region again. The register reads back.
- R8: The register-region bytes at pointers 0x83 and 0x84 are writable only while the configuration bank is unlocked. The other pointers 0x80 to 0x86 are always writable.
- R9: A pointer byte with bit 7 = 0 in the register region raises adc_req with adc_chan = pointer[6:3]. adc_req holds until adc_done. While it is high, every address is left unacknowledged. After adc_done, a read returns {chan, 00, result[9:8]} and then result[7:0].
- R10: mon_halt rises with the acknowledge of a matching address and falls on stop. A refused address does not raise it.
- R11: After reset, SDA is released, mon_halt = 0 and adc_req = 0. The slave pulls SDA low only while it acknowledges or sends data.
- R12: The two memory halves are separate storage at the same pointer values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl | input | 1 | Bus clock as seen on the wire |
| sda | input | 1 | Bus data as seen on the wire |
| a2_pin | input | 1 | Board strap compared with address bit a2 |
| cfg_a2_pin | input | 1 | 1: a2 must match a2_pin; 0: a2 must be 0 |
| cfg_alt_id | input | 1 | Selects 1011 instead of 1010 as memory identifier |
| cfg_cmd_a10 | input | 2 | {a1,a0} answered under identifier 1001 |
| sda_low | output | 1 | 1 pulls SDA low (open-drain driver enable) |
| mon_halt | output | 1 | Halt request to the voltage monitor |
| adc_req | output | 1 | Conversion request, held until adc_done |
| adc_chan | output | 4 | Channel to convert |
| adc_done | input | 1 | One-cycle pulse: result valid |
| adc_data | input | 10 | Conversion result |

## Verification
Four things are checked on every cycle: the halt request rises only together with an acknowledge drive, it always drops after a stop, a pending conversion request and its channel stay steady until done, and SDA is pulled only in the acknowledge and transmit phases. Address decoding, the lock codes, page wrap, commit at stop and the converter result format depend on sequences of bus traffic. Only the bench's scenarios can show these, by reading the stored bytes back over the bus.

// File: rtl/i2c_wp_slave.sv
module i2c_wp_slave #(
  parameter int PAGE_BYTES = 16,
  parameter int CMD_REGS   = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl,
  input  logic       sda,
  input  logic       a2_pin,
  input  logic       cfg_a2_pin,
  input  logic       cfg_alt_id,
  input  logic [1:0] cfg_cmd_a10,
  output logic       sda_low,
  output logic       mon_halt,
  output logic       adc_req,
  output logic [3:0] adc_chan,
  input  logic       adc_done,
  input  logic [9:0] adc_data
);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam int KW = $clog2(CMD_REGS);
  localparam int MEM_BYTES = 512;
  localparam logic [7:0] LOCK_PTR = 8'h87;
  localparam logic [2:0] S_IDLE = 3'd0, S_RX = 3'd1, S_ACK = 3'd2, S_TX = 3'd3, S_RACK = 3'd4;
  localparam logic [1:0] G_CMD = 2'd0, G_M0 = 2'd1, G_M1 = 2'd2, G_CFG = 2'd3;
  localparam logic [1:0] K_ADDR = 2'd0, K_PTR = 2'd1, K_DATA = 2'd2;

  logic [2:0] scl_s, sda_s;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin scl_s <= '1; sda_s <= '1; end
    else begin scl_s <= {scl_s[1:0], scl}; sda_s <= {sda_s[1:0], sda}; end

  wire scl_r    = scl_s[1] & ~scl_s[2];
  wire scl_f    = ~scl_s[1] & scl_s[2];
  wire start_ev = scl_s[1] & scl_s[2] & ~sda_s[1] & sda_s[2];
  wire stop_ev  = scl_s[1] & scl_s[2] & sda_s[1] & ~sda_s[2];

  logic [7:0] mem [MEM_BYTES];
  logic [7:0] cfg [PAGE_BYTES];
  logic [7:0] cmd [CMD_REGS];
  logic [7:0] pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pval;
  logic [7-PW:0] ppage;
  logic [1:0] pgrp, grp, kind;
  logic [2:0] st;
  logic [3:0] cnt;
  logic [7:0] sh, txsh, ptr, lock, rdat;
  logic rd, ack_q, mack, adc_mode, adc_hi;
  logic [9:0] adc_res;

  wire mem_ok = lock[7:4] == 4'b0101;
  wire cfg_ok = lock[3:0] == 4'b0101;
  wire a2ok    = sh[3] == (cfg_a2_pin ? a2_pin : 1'b0);
  wire hit_cmd = sh[7:4] == 4'b1001 && a2ok && sh[2:1] == cfg_cmd_a10;
  wire hit_mem = sh[7:4] == {3'b101, cfg_alt_id} && a2ok && sh[2:1] != 2'b10;
  wire [1:0] grp_sel = hit_cmd ? G_CMD : sh[2:1] == 2'b00 ? G_M0 : sh[2:1] == 2'b01 ? G_M1 : G_CFG;
  wire load = scl_f && ((st == S_ACK && ack_q && rd) || (st == S_RACK && mack));

  always_comb
    case (grp)
      G_CMD:   rdat = adc_mode ? (adc_hi ? adc_res[7:0] : {adc_chan, 2'b00, adc_res[9:8]})
                               : (ptr == LOCK_PTR ? lock : cmd[ptr[KW-1:0]]);
      G_M0:    rdat = mem[{1'b0, ptr}];
      G_M1:    rdat = mem[{1'b1, ptr}];
      default: rdat = cfg[ptr[PW-1:0]];
    endcase

  assign adc_req = adc_mode & ~adc_hi & (st != S_TX) & adc_busy;
  logic adc_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sh <= '0; txsh <= '0; ptr <= '0; lock <= '0;
      sda_low <= 1'b0; mon_halt <= 1'b0; rd <= 1'b0; ack_q <= 1'b0; mack <= 1'b0;
      kind <= K_ADDR; grp <= G_CMD; pgrp <= G_M0; ppage <= '0; pval <= '0;
      adc_mode <= 1'b0; adc_hi <= 1'b0; adc_busy <= 1'b0; adc_chan <= '0; adc_res <= '0;
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) begin cfg[i] <= '0; pbuf[i] <= '0; end
      for (int i = 0; i < CMD_REGS; i++) cmd[i] <= '0;
    end else begin
      if (adc_busy && adc_done) begin adc_busy <= 1'b0; adc_res <= adc_data; end
      if (start_ev) begin
        st <= S_RX; cnt <= '0; kind <= K_ADDR; sda_low <= 1'b0;
      end else if (stop_ev) begin
        st <= S_IDLE; sda_low <= 1'b0; mon_halt <= 1'b0; pval <= '0;
        for (int i = 0; i < PAGE_BYTES; i++)
          if (pval[i]) begin
            if (pgrp == G_M0 && mem_ok) mem[{1'b0, ppage, PW'(i)}] <= pbuf[i];
            if (pgrp == G_M1 && mem_ok) mem[{1'b1, ppage, PW'(i)}] <= pbuf[i];
            if (pgrp == G_CFG && cfg_ok) cfg[PW'(i)] <= pbuf[i];
          end
      end else if (st == S_RX && scl_r && cnt != 4'd8) begin
        sh <= {sh[6:0], sda_s[1]}; cnt <= cnt + 4'd1;
      end else if (st == S_RX && scl_f && cnt == 4'd8) begin
        st <= S_ACK; ack_q <= 1'b1; sda_low <= 1'b1;
        kind <= (kind == K_ADDR) ? K_PTR : K_DATA;
        if (kind == K_ADDR) begin
          if ((hit_cmd || hit_mem) && !adc_busy) begin
            mon_halt <= 1'b1; rd <= sh[0]; grp <= grp_sel;
          end else begin
            ack_q <= 1'b0; sda_low <= 1'b0;
          end
        end else if (kind == K_PTR) begin
          ptr <= sh;
          if (grp == G_CMD) begin
            adc_mode <= ~sh[7]; adc_hi <= 1'b0;
            if (!sh[7]) begin adc_chan <= sh[6:3]; adc_busy <= 1'b1; end
          end else begin
            pval <= '0; pgrp <= grp; ppage <= sh[7:PW];
          end
        end else if (grp == G_CMD) begin
          if (!adc_mode) begin
            if (ptr == LOCK_PTR) lock <= sh;
            else if (cfg_ok || (ptr != 8'h83 && ptr != 8'h84)) cmd[ptr[KW-1:0]] <= sh;
            ptr <= ptr + 8'd1;
          end
        end else begin
          pbuf[ptr[PW-1:0]] <= sh; pval[ptr[PW-1:0]] <= 1'b1;
          ptr <= {ptr[7:PW], ptr[PW-1:0] + PW'(1)};
        end
      end else if (load) begin
        st <= S_TX; sda_low <= ~rdat[7]; txsh <= {rdat[6:0], 1'b0}; cnt <= 4'd1;
        if (grp == G_CMD && adc_mode) adc_hi <= ~adc_hi;
        else ptr <= ptr + 8'd1;
      end else if (st == S_ACK && scl_f) begin
        sda_low <= 1'b0; cnt <= '0;
        st <= ack_q ? S_RX : S_IDLE;
      end else if (st == S_TX && scl_f) begin
        if (cnt != 4'd8) begin
          sda_low <= ~txsh[7]; txsh <= {txsh[6:0], 1'b0}; cnt <= cnt + 4'd1;
        end else begin
          sda_low <= 1'b0; st <= S_RACK;
        end
      end else if (st == S_RACK && scl_r) begin
        mack <= ~sda_s[1];
      end else if (st == S_RACK && scl_f) begin
        st <= S_IDLE;
      end
    end
  end
endmodule

// File: rtl/i2c_wp_chk.sv
module i2c_wp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_low,
  input logic       mon_halt,
  input logic       adc_req,
  input logic       adc_done,
  input logic       stop_ev,
  input logic [2:0] st,
  input logic [3:0] adc_chan
);
  // R10
  halt_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mon_halt) |-> sda_low);
  // R10
  halt_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !mon_halt);
  // R9
  adc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_req && !adc_done && st != 3'd3) |=> (adc_req || st == 3'd3) && $stable(adc_chan));
  // R11
  sda_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_low |-> (st == 3'd2 || st == 3'd3));
endmodule

bind i2c_wp_slave i2c_wp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_low(sda_low), .mon_halt(mon_halt),
  .adc_req(adc_req), .adc_done(adc_done), .stop_ev(stop_ev), .st(st), .adc_chan(adc_chan)
);

// File: tb/tb_i2c_wp_slave.sv
module tb_i2c_wp_slave;
  logic clk = 0, rst_n = 0;
  logic scl = 1, m_low = 0;
  logic a2_pin = 0, cfg_a2_pin = 0, cfg_alt_id = 0;
  logic [1:0] cfg_cmd_a10 = 2'b01;
  logic adc_done = 0;
  logic [9:0] adc_data = '0;
  logic sda_low, mon_halt, adc_req;
  logic [3:0] adc_chan;
  wire sda_bus = ~(m_low | sda_low);
  int tests = 0, fails = 0;
  bit finished = 0;
  logic [7:0] wbuf [32];
  logic [7:0] rbuf [32];

  localparam logic [7:0] CMD = 8'b1001_0010, M0 = 8'b1010_0000, M1 = 8'b1010_0010, CFG = 8'b1010_0110;

  always #10 clk = ~clk;

  i2c_wp_slave dut (.clk(clk), .rst_n(rst_n), .scl(scl), .sda(sda_bus), .a2_pin(a2_pin),
    .cfg_a2_pin(cfg_a2_pin), .cfg_alt_id(cfg_alt_id), .cfg_cmd_a10(cfg_cmd_a10),
    .sda_low(sda_low), .mon_halt(mon_halt), .adc_req(adc_req), .adc_chan(adc_chan),
    .adc_done(adc_done), .adc_data(adc_data));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic w(); repeat (10) @(negedge clk); endtask

  task automatic m_start(); m_low = 0; scl = 1; w(); m_low = 1; w(); scl = 0; w(); endtask
  task automatic m_rstart(); m_low = 0; w(); scl = 1; w(); m_low = 1; w(); scl = 0; w(); endtask
  task automatic m_stop(); m_low = 1; w(); scl = 1; w(); m_low = 0; w(); endtask

  task automatic m_wbyte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; w(); scl = 1; w(); w(); scl = 0; w();
    end
    m_low = 0; w(); scl = 1; w(); ack = ~sda_bus; w(); scl = 0; w();
  endtask

  task automatic m_rbyte(input bit give_ack, output logic [7:0] b);
    m_low = 0;
    for (int i = 7; i >= 0; i--) begin
      w(); scl = 1; w(); b[i] = sda_bus; w(); scl = 0;
    end
    w(); m_low = give_ack; w(); scl = 1; w(); w(); scl = 0; w(); m_low = 0;
  endtask

  task automatic wr_seq(input logic [7:0] dev, input logic [7:0] p, input int n, output bit all_ack);
    bit a;
    m_start(); m_wbyte(dev, a); all_ack = a;
    m_wbyte(p, a); all_ack &= a;
    for (int k = 0; k < n; k++) begin m_wbyte(wbuf[k], a); all_ack &= a; end
    m_stop();
  endtask

  task automatic rd_seq(input logic [7:0] dev, input logic [7:0] p, input int n);
    bit a;
    m_start(); m_wbyte(dev, a); m_wbyte(p, a);
    m_rstart(); m_wbyte(dev | 8'h01, a);
    for (int k = 0; k < n; k++) m_rbyte(k != n - 1, rbuf[k]);
    m_stop();
  endtask

  task automatic wr1(input logic [7:0] dev, input logic [7:0] p, input logic [7:0] d, output bit ack);
    wbuf[0] = d; wr_seq(dev, p, 1, ack);
  endtask

  task automatic probe(input logic [7:0] dev, output bit ack);
    m_start(); m_wbyte(dev, ack); m_stop();
  endtask

  task automatic t_reset();
    chk(sda_low == 0, "R11 sda released", sda_low, 0);
    chk(mon_halt == 0, "R11 halt low", mon_halt, 0);
    chk(adc_req == 0, "R11 no request", adc_req, 0);
  endtask

  task automatic t_lock_default();
    bit a;
    rd_seq(CMD, 8'h87, 1);
    chk(rbuf[0] == 8'h00, "R6 lock reset value", rbuf[0], 0);
    wr1(M0, 8'h10, 8'hAA, a);
    chk(a, "R6 locked write acked", a, 1);
    rd_seq(M0, 8'h10, 1);
    chk(rbuf[0] == 8'h00, "R6 locked write discarded", rbuf[0], 0);
    wr1(CMD, 8'h87, 8'h55, a);
    rd_seq(CMD, 8'h87, 1);
    chk(rbuf[0] == 8'h55, "R7 lock readback", rbuf[0], 8'h55);
  endtask

  task automatic t_write_read();
    bit a;
    wbuf[0] = 8'hA1; wbuf[1] = 8'hA2; wbuf[2] = 8'hA3;
    wr_seq(M0, 8'h20, 3, a);
    chk(a, "R3 write acked", a, 1);
    wbuf[0] = 8'hB1;
    wr_seq(M1, 8'h20, 1, a);
    rd_seq(M0, 8'h20, 3);
    chk(rbuf[0] == 8'hA1 && rbuf[1] == 8'hA2 && rbuf[2] == 8'hA3, "R3 sequential read",
        {rbuf[0], rbuf[1], rbuf[2]}, 24'hA1A2A3);
    rd_seq(M1, 8'h20, 1);
    chk(rbuf[0] == 8'hB1, "R12 high half separate", rbuf[0], 8'hB1);
  endtask

  task automatic t_page_wrap();
    bit a;
    wbuf[0] = 8'hC0; wbuf[1] = 8'hC1; wbuf[2] = 8'hC2;
    wr_seq(M0, 8'h3E, 3, a);
    rd_seq(M0, 8'h30, 1);
    chk(rbuf[0] == 8'hC2, "R4 wrap to page start", rbuf[0], 8'hC2);
    rd_seq(M0, 8'h40, 1);
    chk(rbuf[0] == 8'h00, "R4 next page untouched", rbuf[0], 0);
  endtask

  task automatic t_commit();
    bit a;
    logic [7:0] b;
    m_start(); m_wbyte(M0, a); m_wbyte(8'h60, a);
    for (int k = 0; k < 16; k++) m_wbyte(8'hD0 + 8'(k), a);
    m_rstart(); m_wbyte(M0 | 8'h01, a); m_rbyte(0, b); m_stop();
    chk(b == 8'h00, "R5 old data before stop", b, 0);
    rd_seq(M0, 8'h60, 1);
    chk(rbuf[0] == 8'hD0, "R5 committed at stop", rbuf[0], 8'hD0);
    rd_seq(M0, 8'h6F, 1);
    chk(rbuf[0] == 8'hDF, "R4 sixteenth byte", rbuf[0], 8'hDF);
  endtask

  task automatic t_relock();
    bit a;
    wr1(CMD, 8'h87, 8'h05, a);
    wr1(M0, 8'h20, 8'hEE, a);
    rd_seq(M0, 8'h20, 1);
    chk(rbuf[0] == 8'hA1, "R7 memory relocked", rbuf[0], 8'hA1);
    wr1(CFG, 8'h03, 8'h3C, a);
    rd_seq(CFG, 8'h03, 1);
    chk(rbuf[0] == 8'h3C, "R7 config unlocked", rbuf[0], 8'h3C);
    wr1(CMD, 8'h87, 8'h50, a);
    wr1(CFG, 8'h03, 8'h99, a);
    rd_seq(CFG, 8'h03, 1);
    chk(rbuf[0] == 8'h3C, "R7 config relocked", rbuf[0], 8'h3C);
    wr1(CMD, 8'h83, 8'h12, a);
    rd_seq(CMD, 8'h83, 1);
    chk(rbuf[0] == 8'h00, "R8 extra config locked", rbuf[0], 0);
    wr1(CMD, 8'h81, 8'h34, a);
    rd_seq(CMD, 8'h81, 1);
    chk(rbuf[0] == 8'h34, "R8 command reg free", rbuf[0], 8'h34);
    wr1(CMD, 8'h87, 8'h55, a);
    wr1(CMD, 8'h83, 8'h12, a);
    rd_seq(CMD, 8'h83, 1);
    chk(rbuf[0] == 8'h12, "R8 extra config unlocked", rbuf[0], 8'h12);
  endtask

  task automatic t_decode();
    bit a;
    probe(8'b1100_0000, a);
    chk(!a, "R1 foreign id refused", a, 0);
    chk(mon_halt == 0, "R10 no halt on refusal", mon_halt, 0);
    probe(8'b1010_0100, a);
    chk(!a, "R1 memory a1a0=10 refused", a, 0);
    probe(8'b1001_0000, a);
    chk(!a, "R1 command wrong a1a0", a, 0);
    cfg_alt_id = 1;
    probe(M0, a);
    chk(!a, "R1 1010 refused in alt mode", a, 0);
    probe(8'b1011_0000, a);
    chk(a, "R1 1011 accepted in alt mode", a, 1);
    cfg_alt_id = 0;
    probe(8'b1010_1000, a);
    chk(!a, "R2 a2=1 refused when fixed", a, 0);
    cfg_a2_pin = 1; a2_pin = 1;
    probe(M0, a);
    chk(!a, "R2 a2 mismatch pin", a, 0);
    probe(8'b1010_1000, a);
    chk(a, "R2 a2 matches pin", a, 1);
    cfg_a2_pin = 0; a2_pin = 0;
  endtask

  task automatic t_halt();
    bit a;
    m_start(); m_wbyte(M0, a);
    chk(mon_halt == 1, "R10 halt after ack", mon_halt, 1);
    m_wbyte(8'h00, a);
    chk(mon_halt == 1, "R10 halt held", mon_halt, 1);
    m_stop(); w();
    chk(mon_halt == 0, "R10 halt dropped at stop", mon_halt, 0);
  endtask

  task automatic t_adc();
    bit a;
    logic [7:0] b0, b1;
    m_start(); m_wbyte(CMD, a); m_wbyte(8'h28, a); m_stop();
    chk(adc_req == 1, "R9 request raised", adc_req, 1);
    chk(adc_chan == 4'd5, "R9 channel from pointer", adc_chan, 5);
    probe(CMD | 8'h01, a);
    chk(!a, "R9 address refused while busy", a, 0);
    @(negedge clk); adc_data = 10'h2B7; adc_done = 1;
    @(negedge clk); adc_done = 0; w();
    chk(adc_req == 0, "R9 request cleared", adc_req, 0);
    m_start(); m_wbyte(CMD | 8'h01, a);
    chk(a, "R9 address accepted after done", a, 1);
    m_rbyte(1, b0); m_rbyte(0, b1); m_stop();
    chk(b0 == 8'h52, "R9 echo byte", b0, 8'h52);
    chk(b1 == 8'hB7, "R9 low result byte", b1, 8'hB7);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    t_reset();
    t_lock_default();
    t_write_read();
    t_page_wrap();
    t_commit();
    t_relock();
    t_decode();
    t_halt();
    t_adc();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule